// File: doc/BRIEF.md
# Synchronized System Clock Divider Bank

This block turns one fast clock into a set of divided clock enables, one per output divider. Each divider has a ratio and an on/off bit, held in a 32-bit control word on a simple register bus. Ratios written by software do not take effect straight away. They sit in a pending copy until software writes the GO command. The bank then switches every divider to its new ratio at the same clock edge. A status bit reads as busy until the switch is complete.

When GO arrives, the controller moves from `ST_IDLE` to `ST_DRAIN`. In `ST_DRAIN` each enabled divider runs out its present output period, sends its last enable pulse and then parks with its output low. Once every enabled divider has parked (a disabled divider counts as parked), the controller moves to `ST_COMMIT` for one cycle. In that cycle every divider copies its pending ratio into its active ratio and its counter restarts at zero. The controller then returns to `ST_IDLE`, and all dividers begin counting from the same edge.

The transitions are:
- `ST_IDLE` to `ST_DRAIN` on a GO write.
- `ST_DRAIN` to `ST_COMMIT` when all dividers are ready.
- `ST_COMMIT` to `ST_IDLE` unconditionally.

In every other case the state holds.

Top module: `sysdiv_bank`

## Requirements
- R1: After reset, every divider reads back as enabled with ratio 0 (0x0000_8000), the status register reads 0, and every clock enable output is high in every cycle.
- R2: The divider control words are at these offsets:
  - divider 1 at 0x118, divider 2 at 0x11C, divider 3 at 0x120;
  - dividers 4 to 9 at 0x160 + 4*(n-4).

  In each word, bits [4:0] hold the ratio and bit 15 holds the enable. A read returns the pending ratio and the enable, with every other bit 0. The command register (0x138) and any undecoded offset read as 0.
- R3: A ratio write changes only the pending copy. The clock enable outputs keep following the old active ratios until a GO completes.
- R4: Writing 1 to bit 0 of offset 0x138 while idle starts a GO. Bit 0 of the status register (0x13C) reads 1 from the next cycle and returns to 0 when the new ratios are active.
- R5: Let t = 0 be the first cycle in which busy reads 0 after a GO. From then on, an enabled divider with active ratio r drives its enable high exactly in the cycles where t mod (r+1) = r. A ratio of 0 therefore gives an enable that is high every cycle.
- R6: During a GO, each enabled divider finishes its current period before the switch. Busy lasts at least 2 cycles and at most (largest old active ratio among enabled dividers) + 3 cycles.
- R7: A divider marked fixed by the FIXED_MASK parameter ignores ratio writes, and its ratio stays 0. Its enable bit stays writable.
- R8: A divider whose enable is 0 holds its output low and keeps its counter at zero. After it is enabled again, its first pulse comes in the r-th cycle after the write, and it keeps period r+1 from then on.
- R9: A GO written while busy is already 1 is ignored. Busy clears once, after the first GO completes, and no second switch follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| clk_en | output | NUM_DIV | Divided clock enable, one bit per divider |

## Verification
The assertions assume that reset is held for at least one edge before any register access. They also assume the write strobe lasts one cycle, with address and data stable around the edge. The bench drives the bus only on falling edges and drops the strobe on the following falling edge, so each write lands on exactly one rising edge. The busy-length bound takes for granted that software does not change enables while a GO is draining. The bench therefore writes all ratios and enables before issuing GO, and issues nothing during the drain except the deliberately ignored second GO.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_COMMIT = 2'd2
    } go_state_t;

    localparam int          EN_BIT   = 15;
    localparam logic [11:0] CMD_OFS  = 12'h138;
    localparam logic [11:0] STAT_OFS = 12'h13C;

    // Control words sit in two separate runs of the address space.
    function automatic logic [11:0] div_offset(input int idx);
        logic [11:0] o;
        if (idx < 3) o = 12'h118 + 12'(4 * idx);
        else         o = 12'h160 + 12'(4 * (idx - 3));
        return o;
    endfunction

endpackage

// File: rtl/sysdiv_regs.sv
module sysdiv_regs
    import sysdiv_pkg::*;
#(
    parameter int NUM_DIV    = 9,
    parameter int RATIO_W    = 5,
    parameter int ADDR_W     = 12,
    parameter logic [NUM_DIV-1:0] FIXED_MASK = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [31:0]                     wdata,
    input  logic                            busy,
    output logic [31:0]                     rdata,
    output logic [NUM_DIV-1:0][RATIO_W-1:0] pend,
    output logic [NUM_DIV-1:0]              div_en,
    output logic                            go_wr
);

    logic [NUM_DIV-1:0] hit;

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_word
        assign hit[i] = (addr == ADDR_W'(div_offset(i)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_en[i] <= 1'b1;
            else if (we && hit[i])   div_en[i] <= wdata[EN_BIT];
        end

        if (FIXED_MASK[i]) begin : g_fixed
            assign pend[i] = '0;
        end else begin : g_prog
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            pend[i] <= '0;
                else if (we && hit[i]) pend[i] <= wdata[RATIO_W-1:0];
            end
        end
    end

    assign go_wr = we && (addr == ADDR_W'(CMD_OFS)) && wdata[0];

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_DIV; k++) begin
            if (hit[k]) begin
                rdata[EN_BIT]        = div_en[k];
                rdata[RATIO_W-1:0]   = pend[k];
            end
        end
        if (addr == ADDR_W'(STAT_OFS)) rdata[0] = busy;
    end

endmodule

// File: rtl/sysdiv_ctrl.sv
module sysdiv_ctrl
    import sysdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_wr,
    input  logic all_ready,
    output logic busy,
    output logic align,
    output logic apply
);

    go_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go_wr)     nxt = ST_DRAIN;
            ST_DRAIN:  if (all_ready) nxt = ST_COMMIT;
            ST_COMMIT:                nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state != ST_IDLE);
        align = (state == ST_DRAIN);
        apply = (state == ST_COMMIT);
    end

    AST_COMMIT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> $past(all_ready)); // R6
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state == ST_IDLE)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !go_wr) |=> (state == ST_IDLE)); // R4

endmodule

// File: rtl/sysdiv_counter.sv
module sysdiv_counter #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] pend,
    input  logic               align,
    input  logic               apply,
    output logic               tick,
    output logic               ready
);

    logic [RATIO_W-1:0] cnt, act;
    logic               parked;

    assign tick  = en && !parked && (cnt == act);
    assign ready = !en || parked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            act    <= '0;
            parked <= 1'b0;
        end else begin
            if (apply) act <= pend;
            if (!en || apply) begin
                cnt    <= '0;
                parked <= 1'b0;
            end else if (!parked) begin
                if (cnt == act) begin
                    cnt    <= '0;
                    parked <= align;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_ACTIVE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act)); // R3
    AST_PARK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> (align || apply)); // R6
    AST_BACK_TO_BACK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |-> (act == '0)); // R5

endmodule

// File: rtl/sysdiv_bank.sv
module sysdiv_bank
    import sysdiv_pkg::*;
#(
    parameter int NUM_DIV = 9,
    parameter int RATIO_W = 5,
    parameter int ADDR_W  = 12,
    parameter logic [NUM_DIV-1:0] FIXED_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_DIV-1:0] clk_en
);

    logic [NUM_DIV-1:0][RATIO_W-1:0] pend;
    logic [NUM_DIV-1:0]              div_en;
    logic [NUM_DIV-1:0]              ready;
    logic go_wr, busy, align, apply;

    sysdiv_regs #(
        .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W), .FIXED_MASK(FIXED_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .rdata(reg_rdata), .pend(pend), .div_en(div_en), .go_wr(go_wr)
    );

    sysdiv_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .all_ready(&ready),
        .busy(busy), .align(align), .apply(apply)
    );

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        sysdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en(div_en[i]), .pend(pend[i]),
            .align(align), .apply(apply), .tick(clk_en[i]), .ready(ready[i])
        );

        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !div_en[i] |-> !clk_en[i]); // R8
    end

endmodule

// File: tb/sim_sysdiv_bank.sv
module sim_sysdiv_bank;
    import sysdiv_pkg::*;

    localparam int N = 9;
    localparam logic [N-1:0] FIXED = 9'b0_0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] clk_en;

    int tests = 0;
    int fails = 0;
    int act_r [N];
    int new_r [N];
    logic [N-1:0] en_mask;

    always #5 clk = ~clk;

    sysdiv_bank #(.NUM_DIV(N), .RATIO_W(5), .ADDR_W(12), .FIXED_MASK(FIXED)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [N-1:0] exp_vec(input int t);
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++)
            v[i] = en_mask[i] && ((t % (act_r[i] + 1)) == act_r[i]);
        return v;
    endfunction

    // Write a pattern, issue GO (optionally twice), then check the aligned restart.
    task automatic run_pattern(input string tag, input bit check_stage, input bit double_go);
        logic [31:0] d;
        int maxr, cyc;
        for (int i = 0; i < N; i++)
            wr(div_offset(i), {16'h0, en_mask[i], 10'h0, 5'(new_r[i])});
        for (int i = 0; i < N; i++) begin
            rd(div_offset(i), d);
            chk({tag, " R2/R7 readback"}, d,
                {16'h0, en_mask[i], 10'h0, (FIXED[i] ? 5'd0 : 5'(new_r[i]))});
        end
        if (check_stage) begin
            for (int c = 0; c < 5; c++) begin
                @(negedge clk); #1;
                chk({tag, " R3 staged, output unchanged"}, 32'(clk_en), 32'(exp_vec(0)));
            end
        end
        maxr = 0;
        for (int i = 0; i < N; i++)
            if (en_mask[i] && act_r[i] > maxr) maxr = act_r[i];
        wr(CMD_OFS, 32'h1);
        cyc = 0;
        if (double_go) begin
            wr(CMD_OFS, 32'h1);
            cyc = 2;
        end
        reg_addr = STAT_OFS;
        forever begin
            #1;
            if (!reg_rdata[0]) break;
            cyc++;
            if (cyc > 200) break;
            @(negedge clk);
        end
        chk({tag, " R4 busy seen then cleared"}, 32'((cyc >= 1) && (cyc <= 200)), 32'd1);
        chk({tag, " R6 busy length bound"}, 32'((cyc >= 2) && (cyc <= maxr + 3)), 32'd1);
        for (int i = 0; i < N; i++) act_r[i] = FIXED[i] ? 0 : new_r[i];
        for (int t = 0; t < 70; t++) begin
            chk({tag, " R5 aligned divided enables"}, 32'(clk_en), 32'(exp_vec(t)));
            @(negedge clk); #2;
        end
        rd(STAT_OFS, d);
        chk({tag, " R9 no second switch, idle"}, d, 32'h0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < N; i++) act_r[i] = 0;
        en_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < N; i++) begin
            rd(div_offset(i), d);
            chk("R1 reset word", d, 32'h0000_8000);
        end
        rd(STAT_OFS, d);
        chk("R1 reset status", d, 32'h0);
        chk("R1 reset outputs", 32'(clk_en), 32'(9'h1FF));

        // R2 field masking and undecoded offsets
        wr(div_offset(0), 32'hFFFF_FFFF);
        rd(div_offset(0), d);
        chk("R2 unused bits read 0", d, 32'h0000_801F);
        rd(12'h124, d);
        chk("R2 undecoded offset", d, 32'h0);
        rd(CMD_OFS, d);
        chk("R2 command reads 0", d, 32'h0);

        // R7 fixed divider: ratio ignored, enable writable
        wr(div_offset(2), 32'h0000_0007);
        rd(div_offset(2), d);
        chk("R7 fixed ratio ignored, enable cleared", d, 32'h0);
        wr(div_offset(2), 32'h0000_8005);
        rd(div_offset(2), d);
        chk("R7 fixed enable set", d, 32'h0000_8000);

        // Pattern A: one divider off, spread ratios
        for (int i = 0; i < N; i++) new_r[i] = (i * 7 + 1) % 32;
        en_mask = 9'b1_1110_1111;
        run_pattern("A", 1'b1, 1'b0);

        // Pattern B: near-maximum ratios, second GO during busy (R9)
        for (int i = 0; i < N; i++) new_r[i] = 31 - i;
        en_mask = '1;
        run_pattern("B", 1'b0, 1'b1);

        // Pattern C: small ratios incl. passthrough, alternate enables
        for (int i = 0; i < N; i++) new_r[i] = i % 3;
        en_mask = 9'b1_0101_0101;
        run_pattern("C", 1'b0, 1'b0);

        // R8 disable then re-enable divider 5 (index 4, ratio 1)
        wr(div_offset(4), 32'h0000_0001);
        for (int c = 0; c < 8; c++) begin
            chk("R8 disabled output low", 32'(clk_en[4]), 32'd0);
            @(negedge clk); #1;
        end
        wr(div_offset(4), 32'h0000_8001);
        for (int t = 0; t < 8; t++) begin
            chk("R8 re-enabled phase", 32'(clk_en[4]), 32'((t % 2) == 1));
            @(negedge clk); #1;
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule